// File: doc/BRIEF.md
# General-Purpose Event Status and Enable Bank

This block holds the general-purpose event registers of a power-management unit. It owns a byte-addressed window of `LEN` bytes on a simple I/O bus. The window begins at a base address that software programs, and the block decodes accesses by subtracting that base from the bus address. The lower half of the window holds the status bytes and the upper half holds the enable bytes. The block has `LEN/2` bytes of each kind.

Hardware events set status bits. There is one set pulse for each status bit, plus two slot-hotplug pulses, for an insertion and for a removal. Both hotplug pulses set a single hotplug bit in status byte 0. Software clears a status bit by writing a one to it, and it writes enable bytes directly. The block raises a pending level toward the system control interrupt logic while the hotplug status bit and its enable bit are both set. An access that falls outside the window has no effect on state, reads as zero, and raises an error flag for one cycle.

Top module: `gpe_bank`

## Requirements
- R1: Decoding uses the offset `addr_i - base_i`, taken modulo 2^ADDR_W. Changing `base_i` moves the whole window, and an address below the base wraps to an offset outside the window.
- R2: An offset `k` below `LEN/2` selects status byte `k`. Event bit `i` belongs to status byte `i/8`, bit `i%8`.
- R3: An offset `k` from `LEN/2` to `LEN-1` selects enable byte `k - LEN/2`.
- R4: A write to a status byte clears each bit written as 1 and leaves each bit written as 0 unchanged. No status bit ever clears without a write.
- R5: A write to an enable byte replaces all eight of its bits with `wdata_i`. The new value is visible from the cycle after the write.
- R6: While `rd_i` is high, `rdata_o` combinationally shows the selected byte. While `rd_i` is low, it shows 0x00.
- R7: An active-low reset zeroes every status byte and every enable byte, and drops `pending_o` and `err_o`.
- R8: A pulse on `hp_insert_i` or on `hp_remove_i` sets bit `HP_BIT` (default 1) of status byte 0 on the next clock edge.
- R9: `pending_o` is high exactly when bit `HP_BIT` of status byte 0 and bit `HP_BIT` of enable byte 0 are both set. Other enabled status bits do not raise it.
- R10: A read or write at an offset of `LEN` or more changes no state and reads 0x00. It also raises `err_o` for the following cycle. An in-window access leaves `err_o` low in the following cycle.
- R11: When a hardware set and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R12: A pulse on `evt_set_i[i]` sets its status bit on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_i | input | ADDR_W | Programmed start address of the window |
| addr_i | input | ADDR_W | Bus byte address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| evt_set_i | input | LEN/2*8 | Per-bit status set pulses |
| hp_insert_i | input | 1 | Slot insertion event |
| hp_remove_i | input | 1 | Slot removal event |
| pending_o | output | 1 | Hotplug event pending toward the interrupt logic |
| err_o | output | 1 | Out-of-window access flag, one cycle late |

## Verification
Write-one-to-clear patterns with all-zero and single-one data distinguish a clear mask from a plain store. Repeated enable writes of different values distinguish replacement from accumulation. A hardware set driven in the same cycle as a clearing write shows which side has priority. Reads at offsets just beyond the window, below the base, and at the old base after the base has moved separate window bounds from subtraction wraparound. An enabled non-hotplug event shows that only the hotplug pair drives the pending level.

// File: rtl/gpe_pkg.sv
package gpe_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STS  = 2'd1,
    SEL_EN   = 2'd2,
    SEL_BAD  = 2'd3
  } gpe_sel_e;

  // Set has priority over clear so that an event is never lost.
  function automatic logic [7:0] status_next(input logic [7:0] cur,
                                             input logic [7:0] clr,
                                             input logic [7:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/gpe_addr_decode.sv
module gpe_addr_decode #(
  parameter int ADDR_W = 16,
  parameter int LEN    = 4
) (
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [ADDR_W-1:0]     base_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  output logic [ADDR_W-1:0]     off_o,
  output gpe_pkg::gpe_sel_e     sel_o,
  output logic [ADDR_W-1:0]     idx_o,
  output logic                  sts_wr_o,
  output logic                  en_wr_o,
  output logic                  bad_o
);
  import gpe_pkg::*;

  localparam int HALF = LEN / 2;
  localparam logic [ADDR_W-1:0] HALF_A = ADDR_W'(HALF);
  localparam logic [ADDR_W-1:0] LEN_A  = ADDR_W'(LEN);

  function automatic logic [ADDR_W-1:0] rel_offset(input logic [ADDR_W-1:0] a,
                                                   input logic [ADDR_W-1:0] b);
    return a - b;
  endfunction

  function automatic gpe_sel_e classify(input logic [ADDR_W-1:0] o);
    if (o < HALF_A)     return SEL_STS;
    else if (o < LEN_A) return SEL_EN;
    else                return SEL_BAD;
  endfunction

  function automatic logic [ADDR_W-1:0] lane(input logic [ADDR_W-1:0] o);
    return (o < HALF_A) ? o : (o - HALF_A);
  endfunction

  logic access;
  assign access = wr_i | rd_i;

  always_comb begin
    off_o = rel_offset(addr_i, base_i);
    sel_o = access ? classify(off_o) : SEL_NONE;
    idx_o = lane(off_o);
  end

  assign sts_wr_o = wr_i && (sel_o == SEL_STS);
  assign en_wr_o  = wr_i && (sel_o == SEL_EN);
  assign bad_o    = sel_o == SEL_BAD;

endmodule

// File: rtl/gpe_status_bank.sv
module gpe_status_bank #(
  parameter int NBYTES = 2,
  parameter int HP_BIT = 1,
  parameter int IDX_W  = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [7:0]            wdata_i,
  input  logic [NBYTES*8-1:0]   evt_i,
  input  logic                  hp_set_i,
  output logic [NBYTES*8-1:0]   q_o
);
  localparam logic [7:0] HP_MASK = 8'(1) << HP_BIT;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [7:0] q, clr_m, set_m;

    assign clr_m = (wr_i && idx_i == IDX_W'(g)) ? wdata_i : 8'h00;

    if (g == 0) begin : g_hp
      assign set_m = evt_i[7:0] | (hp_set_i ? HP_MASK : 8'h00);
    end else begin : g_plain
      assign set_m = evt_i[g*8 +: 8];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 8'h00;
      else         q <= gpe_pkg::status_next(q, clr_m, set_m);
    end

    assign q_o[g*8 +: 8] = q;
  end

endmodule

// File: rtl/gpe_enable_bank.sv
module gpe_enable_bank #(
  parameter int NBYTES = 2,
  parameter int IDX_W  = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [7:0]            wdata_i,
  output logic [NBYTES*8-1:0]   q_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q <= 8'h00;
      else if (wr_i && idx_i == IDX_W'(g))  q <= wdata_i;
    end
    assign q_o[g*8 +: 8] = q;
  end
endmodule

// File: rtl/gpe_read_mux.sv
module gpe_read_mux #(
  parameter int NBYTES = 2,
  parameter int IDX_W  = 16
) (
  input  logic                  rd_i,
  input  gpe_pkg::gpe_sel_e     sel_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [NBYTES*8-1:0]   sts_i,
  input  logic [NBYTES*8-1:0]   en_i,
  output logic [7:0]            rdata_o
);
  import gpe_pkg::*;

  always_comb begin
    rdata_o = 8'h00;
    for (int g = 0; g < NBYTES; g++) begin
      if (rd_i && idx_i == IDX_W'(g)) begin
        if (sel_i == SEL_STS) rdata_o = sts_i[g*8 +: 8];
        if (sel_i == SEL_EN)  rdata_o = en_i[g*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/gpe_bank.sv
module gpe_bank #(
  parameter int ADDR_W = 16,
  parameter int LEN    = 4,
  parameter int HP_BIT = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     base_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [7:0]            wdata_i,
  output logic [7:0]            rdata_o,
  input  logic [LEN/2*8-1:0]    evt_set_i,
  input  logic                  hp_insert_i,
  input  logic                  hp_remove_i,
  output logic                  pending_o,
  output logic                  err_o
);
  localparam int HALF = LEN / 2;
  localparam int NBITS = HALF * 8;

  if (LEN < 2 || (LEN % 2) != 0) begin : g_bad_len
    $error("gpe_bank: LEN must be even and at least 2");
  end
  if (HP_BIT < 0 || HP_BIT > 7) begin : g_bad_hp
    $error("gpe_bank: HP_BIT must lie in byte 0");
  end

  // Named internal events, observed by the bound checker.
  logic [ADDR_W-1:0]  off_w;
  gpe_pkg::gpe_sel_e  sel_w;
  logic [ADDR_W-1:0]  idx_w;
  logic               sts_wr_w;
  logic               en_wr_w;
  logic               bad_w;
  logic               hp_set_w;
  logic [NBITS-1:0]   sts_flat;
  logic [NBITS-1:0]   en_flat;

  assign hp_set_w = hp_insert_i | hp_remove_i;

  gpe_addr_decode #(.ADDR_W(ADDR_W), .LEN(LEN)) u_dec (
    .addr_i   (addr_i),
    .base_i   (base_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .off_o    (off_w),
    .sel_o    (sel_w),
    .idx_o    (idx_w),
    .sts_wr_o (sts_wr_w),
    .en_wr_o  (en_wr_w),
    .bad_o    (bad_w)
  );

  gpe_status_bank #(.NBYTES(HALF), .HP_BIT(HP_BIT), .IDX_W(ADDR_W)) u_sts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (sts_wr_w),
    .idx_i    (idx_w),
    .wdata_i  (wdata_i),
    .evt_i    (evt_set_i),
    .hp_set_i (hp_set_w),
    .q_o      (sts_flat)
  );

  gpe_enable_bank #(.NBYTES(HALF), .IDX_W(ADDR_W)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (en_wr_w),
    .idx_i   (idx_w),
    .wdata_i (wdata_i),
    .q_o     (en_flat)
  );

  gpe_read_mux #(.NBYTES(HALF), .IDX_W(ADDR_W)) u_rmux (
    .rd_i    (rd_i),
    .sel_i   (sel_w),
    .idx_i   (idx_w),
    .sts_i   (sts_flat),
    .en_i    (en_flat),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= bad_w;
  end

  assign pending_o = sts_flat[HP_BIT] & en_flat[HP_BIT];

endmodule

// File: rtl/gpe_bank_chk.sv
module gpe_bank_chk #(
  parameter int ADDR_W = 16,
  parameter int LEN    = 4,
  parameter int HP_BIT = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [7:0]            wdata_i,
  input  logic [7:0]            rdata_o,
  input  logic                  hp_insert_i,
  input  logic                  hp_remove_i,
  input  logic                  pending_o,
  input  logic                  err_o,
  input  logic                  bad_w,
  input  logic                  en_wr_w,
  input  logic [ADDR_W-1:0]     idx_w,
  input  logic [LEN/2*8-1:0]    sts_flat,
  input  logic [LEN/2*8-1:0]    en_flat
);
  a_r10_err_after_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_w |=> err_o);

  a_r10_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_w |=> !err_o);

  a_r10_bad_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_w && wr_i) |=> $stable(en_flat));

  a_r4_no_silent_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> &(sts_flat | ~$past(sts_flat)));

  a_r8_hotplug_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hp_insert_i || hp_remove_i) |=> sts_flat[HP_BIT]);

  a_r5_enable_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_wr_w && idx_w == '0) |=> en_flat[7:0] == $past(wdata_i));

  a_r9_pending_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && !wr_i) |=> pending_o);

  a_r6_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == 8'h00);
endmodule

bind gpe_bank gpe_bank_chk #(.ADDR_W(ADDR_W), .LEN(LEN), .HP_BIT(HP_BIT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .hp_insert_i (hp_insert_i),
  .hp_remove_i (hp_remove_i),
  .pending_o   (pending_o),
  .err_o       (err_o),
  .bad_w       (bad_w),
  .en_wr_w     (en_wr_w),
  .idx_w       (idx_w),
  .sts_flat    (sts_flat),
  .en_flat     (en_flat)
);

// File: tb/gpe_bank_tb.sv
module gpe_bank_tb;
  localparam int AW = 16;
  localparam int LEN = 4;
  localparam int HALF = LEN / 2;
  localparam int HPB = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] base = 16'h0B00;
  logic [AW-1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [HALF*8-1:0] evt = '0;
  logic hp_in = 1'b0, hp_out = 1'b0;
  logic pending, err;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpe_bank #(.ADDR_W(AW), .LEN(LEN), .HP_BIT(HPB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .base_i(base), .addr_i(addr),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata),
    .evt_set_i(evt), .hp_insert_i(hp_in), .hp_remove_i(hp_out),
    .pending_o(pending), .err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_sts[HALF];
  int m_en[HALF];
  int m_err = 0;

  function automatic int rel(input logic [AW-1:0] a);
    int d;
    d = (int'(a) - int'(base)) % 65536;
    if (d < 0) d += 65536;
    return d;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_sts[i]) begin m_sts[i] = 0; m_en[i] = 0; end
      m_err = 0;
    end else begin
      int o;
      o = rel(addr);
      m_err = ((wr || rd) && o >= LEN) ? 1 : 0;
      if (wr && o < HALF) m_sts[o] = m_sts[o] & ~int'(wdata) & 255;
      else if (wr && o < LEN) m_en[o - HALF] = int'(wdata);
      for (int b = 0; b < HALF * 8; b++)
        if (evt[b]) m_sts[b / 8] = m_sts[b / 8] | (1 << (b % 8));
      if (hp_in || hp_out) m_sts[0] = m_sts[0] | (1 << HPB);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int o, exp_rd;
      o = rel(addr);
      exp_rd = 0;
      if (rd && o < HALF) exp_rd = m_sts[o];
      else if (rd && o < LEN) exp_rd = m_en[o - HALF];
      chk("R6 model rdata", int'(rdata), exp_rd);
      chk("R9 model pending", int'(pending), (m_sts[0] >> HPB) & (m_en[0] >> HPB) & 1);
      chk("R10 model err", int'(err), m_err);
    end
  end

  task automatic wr_at(input logic [AW-1:0] a, input logic [7:0] d, output int e);
    @(posedge clk); #2 addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #2 wr = 1'b0;
    #3 e = int'(err);
  endtask

  task automatic rd_at(input logic [AW-1:0] a, output int v, output int e);
    @(posedge clk); #2 addr = a; rd = 1'b1;
    #3 v = int'(rdata);
    @(posedge clk); #2 rd = 1'b0;
    #3 e = int'(err);
  endtask

  task automatic pulse(input logic [HALF*8-1:0] ev, input logic ins, input logic rem);
    @(posedge clk); #2 evt = ev; hp_in = ins; hp_out = rem;
    @(posedge clk); #2 evt = '0; hp_in = 1'b0; hp_out = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk); #2 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, e;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R7 reset state
    rd_at(base + 0, v, e); chk("R7 sts0 after reset", v, 0);
    rd_at(base + 2, v, e); chk("R7 en0 after reset", v, 0);
    chk("R7 pending after reset", int'(pending), 0);
    // R3 and R5 enable writes replace
    wr_at(base + 2, 8'hFF, e);
    rd_at(base + 2, v, e); chk("R3 en0 read", v, 8'hFF);
    wr_at(base + 2, 8'h02, e);
    rd_at(base + 2, v, e); chk("R5 en0 replaced", v, 8'h02);
    // R8 insertion and R9 pending
    pulse('0, 1'b1, 1'b0);
    rd_at(base + 0, v, e); chk("R8 insert sets hp bit", v, 8'h02);
    chk("R9 pending with enable", int'(pending), 1);
    // R4 write one to clear
    wr_at(base + 0, 8'h00, e);
    rd_at(base + 0, v, e); chk("R4 zero write keeps", v, 8'h02);
    wr_at(base + 0, 8'h02, e);
    rd_at(base + 0, v, e); chk("R4 one write clears", v, 8'h00);
    chk("R9 pending drops", int'(pending), 0);
    // R8 removal
    pulse('0, 1'b0, 1'b1);
    rd_at(base + 0, v, e); chk("R8 remove sets hp bit", v, 8'h02);
    // R12 and R2: event bit 12 lands in status byte 1 bit 4
    pulse(16'h1000, 1'b0, 1'b0);
    rd_at(base + 1, v, e); chk("R12 evt bit12 in sts1", v, 8'h10);
    wr_at(base + 3, 8'h10, e);
    rd_at(base + 3, v, e); chk("R3 en1 read", v, 8'h10);
    // R9 other enabled bits do not drive pending
    wr_at(base + 0, 8'h02, e);
    wr_at(base + 2, 8'hFF, e);
    pulse(16'h0001, 1'b0, 1'b0);
    rd_at(base + 0, v, e); chk("R2 sts0 bit0", v, 8'h01);
    chk("R9 non-hotplug bit ignored", int'(pending), 0);
    // R11 set beats clear in the same cycle
    @(posedge clk); #2 addr = base; wdata = 8'h03; wr = 1'b1; hp_in = 1'b1;
    @(posedge clk); #2 wr = 1'b0; hp_in = 1'b0;
    rd_at(base + 0, v, e); chk("R11 set wins", v, 8'h02);
    chk("R11 pending kept", int'(pending), 1);
    // R10 out of window
    wr_at(base + 4, 8'hAA, e); chk("R10 bad write err", e, 1);
    rd_at(base + 2, v, e); chk("R10 en0 untouched", v, 8'hFF);
    chk("R10 err clears after good access", e, 0);
    rd_at(base + 3, v, e); chk("R10 en1 untouched", v, 8'h10);
    rd_at(base + 5, v, e); chk("R10 bad read zero", v, 0);
    chk("R10 bad read err", e, 1);
    // R1 base relative decode
    rd_at(base - 1, v, e); chk("R1 below base err", e, 1);
    @(posedge clk); #2 base = 16'h0C40;
    rd_at(16'h0C42, v, e); chk("R1 moved base en0", v, 8'hFF);
    rd_at(16'h0B02, v, e); chk("R1 old base read zero", v, 0);
    chk("R1 old base err", e, 1);
    // R7 reset again
    do_reset();
    rd_at(base + 0, v, e); chk("R7 sts0 cleared", v, 0);
    rd_at(base + 1, v, e); chk("R7 sts1 cleared", v, 0);
    rd_at(base + 2, v, e); chk("R7 en0 cleared", v, 0);
    chk("R7 pending cleared", int'(pending), 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule